// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block decides which external memory bank owns each bus address. It holds twelve banks. Each bank has a base register and an option register. The base register carries a stored base and an enable bit. The option register carries a compare mask. For each strobed address the block compares the upper seventeen address bits with every enabled bank, but only on the bits its mask selects. The lowest-numbered matching bank wins. One cycle later the block raises that bank's select line, along with the bank index and a hit flag.

Software can rewrite both registers of any bank at any time through a small write/read port. This lets firmware relocate memories while it runs, for example to move RAM to address zero after boot. At reset only bank 0 is enabled. A strap input chooses whether bank 0 sits at the top or at the bottom of the address space. Bank 0 also starts with a coarse mask, so the boot device is reachable before any code runs. If software clears that mask, the boot device answers at every address, which firmware can use to keep fetching while it relocates.

Top module: `csdec_top`

## Requirements
- R1: Every bank has two registers, each written and read back through the configuration port. `cfg_kind`=0 selects the base register, laid out as base in bits 31:15 and enable in bit 0, with all other bits read as zero. `cfg_kind`=1 selects the option register, laid out as mask in bits 31:15, with all other bits read as zero.
- R2: A bank matches when its enable bit is 1 and, for every mask bit that is 1, the corresponding address bit (31 down to 15) equals the stored base bit.
- R3: Address bits 14:0 never affect decoding, so each matching region is a multiple of 32 KB.
- R4: When several banks match, only the lowest-numbered one is selected. The select vector has at most one bit set, and `cs_bank` names that bit.
- R5: After reset, bank 0's mask is 0x1FC00: only address bits 31:25 are compared, which gives a 32 MB window.
- R6: After reset, bank 0 is enabled. Its base is 0xFE00_0000 when `boot_low`=0 and 0x0000_0000 when `boot_low`=1.
- R7: A mask with non-contiguous 1 bits makes one bank answer in several separate regions of the address map.
- R8: When bank 0 is enabled with an all-zero mask, it matches every address.
- R9: After reset, banks 1 to 11 are disabled and match nothing, even though their mask is zero.
- R10: A register write takes effect in the next cycle. An address strobed in the same cycle as the write is decoded with the old contents.
- R11: When no enabled bank matches, `cs` is all zero, `cs_hit` is 0 and `cs_bank` is 0.
- R12: The outputs are registered and describe the address strobed in the previous cycle. After a cycle with no strobe, all outputs are zero.
- R13: Writes with `cfg_sel` of 12 or above change nothing. Reads at those indices return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_low | input | 1 | Boot strap: 1 places bank 0 at address 0 after reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Bank index for both write and read |
| cfg_kind | input | 1 | 0 = base register, 1 = option register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read of the selected register |
| bus_valid | input | 1 | Address strobe |
| bus_addr | input | 32 | Bus address |
| cs | output | 12 | One-hot bank select, registered |
| cs_bank | output | 4 | Index of the selected bank, registered |
| cs_hit | output | 1 | Some bank matched, registered |

## Verification
Both strap settings are checked with addresses inside, at the edge of and just outside the boot window. This separates a wrong base from a wrong mask width.

A sweep over the top seven address bits, and a second sweep of 256 scattered addresses across an overlapping and non-contiguous bank set, are each compared with an arithmetic model. These sweeps catch a broken comparator, priority order or alias pattern.

Directed probes cover the following:
- low-bit changes at a 32 KB edge;
- an all-zero bank 0 mask;
- a write in the same cycle as a strobe, which separates old-value from new-value decoding;
- out-of-range writes;
- idle cycles.

// File: rtl/csdec_pkg.sv
// Package: shared sizes, register layout and reset constants for the
// chip-select decoder. Assumes a 32-bit byte address and 32 KB granularity.
package csdec_pkg;
    parameter int NUM_BANKS = 12;
    parameter int ADDR_W    = 32;
    parameter int CMP_W     = 17;
    localparam int LOW_W    = ADDR_W - CMP_W;
    localparam int IDX_W    = $clog2(NUM_BANKS);

    typedef logic [CMP_W-1:0] field_t;

    typedef struct packed {
        field_t base;
        field_t mask;
        logic   valid;
    } bank_cfg_t;

    typedef enum logic {
        KIND_BASE = 1'b0,
        KIND_OPT  = 1'b1
    } reg_kind_e;

    localparam field_t BOOT_MASK    = 17'h1FC00;
    localparam field_t BOOT_HI_BASE = 17'h1FC00;
    localparam field_t BOOT_LO_BASE = 17'h00000;
endpackage

// File: rtl/csdec_regfile.sv
// Module: per-bank base/option register storage with strap-driven reset
// and a combinational read mux. Assumes one write per cycle; indices at or
// above NUM_BANKS are ignored on write and read as zero.
module csdec_regfile
    import csdec_pkg::*;
#(
    parameter int BANKS = NUM_BANKS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        boot_low,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            sel,
    input  logic                        kind,
    input  logic [ADDR_W-1:0]           wr_data,
    output logic [ADDR_W-1:0]           rd_data,
    output bank_cfg_t [BANKS-1:0]       cfg_q
);
    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data[LOW_W-1:1];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic hit_w;
        assign hit_w = wr_en && (sel == IDX_W'(b));

        // Holds one bank's registers; bank 0 resets to the boot window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                if (b == 0) begin
                    cfg_q[b].base  <= boot_low ? BOOT_LO_BASE : BOOT_HI_BASE;
                    cfg_q[b].mask  <= BOOT_MASK;
                    cfg_q[b].valid <= 1'b1;
                end else begin
                    cfg_q[b] <= '0;
                end
            end else if (hit_w) begin
                if (kind == KIND_BASE) begin
                    cfg_q[b].base  <= wr_data[ADDR_W-1:LOW_W];
                    cfg_q[b].valid <= wr_data[0];
                end else begin
                    cfg_q[b].mask  <= wr_data[ADDR_W-1:LOW_W];
                end
            end
        end
    end

    // Selects the addressed register and formats it for read-back.
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (sel == IDX_W'(b)) begin
                if (kind == KIND_BASE)
                    rd_data = {cfg_q[b].base, {(LOW_W-1){1'b0}}, cfg_q[b].valid};
                else
                    rd_data = {cfg_q[b].mask, {LOW_W{1'b0}}};
            end
        end
    end

    // R10: a base write to bank 0 is visible in the following cycle.
    p_base_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == '0 && kind == KIND_BASE)
        |=> cfg_q[0].base == $past(wr_data[ADDR_W-1:LOW_W]));

    // R13: register contents stay put when no write is issued.
    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));

    // R9: right after reset only bank 0 is enabled.
    p_reset_valid_r9: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> cfg_q[BANKS-1].valid == 1'b0 && cfg_q[0].valid);
endmodule

// File: rtl/csdec_match.sv
// Module: parallel masked comparators, one per bank. Purely combinational;
// assumes only the upper CMP_W address bits are presented.
module csdec_match
    import csdec_pkg::*;
#(
    parameter int BANKS = NUM_BANKS
) (
    input  bank_cfg_t [BANKS-1:0] cfg,
    input  field_t                addr_hi,
    output logic [BANKS-1:0]      hits
);
    for (genvar b = 0; b < BANKS; b++) begin : g_cmp
        // Flags a bank whose enabled, unmasked bits equal the address.
        always_comb begin
            hits[b] = cfg[b].valid && (((addr_hi ^ cfg[b].base) & cfg[b].mask) == '0);
        end
    end
endmodule

// File: rtl/csdec_prio.sv
// Module: fixed-priority resolver (lowest index wins) and output register.
// Assumes hits are already qualified by each bank's enable bit.
module csdec_prio
    import csdec_pkg::*;
#(
    parameter int BANKS = NUM_BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [BANKS-1:0]  hits,
    output logic [BANKS-1:0]  cs_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic              hit_q
);
    logic [IDX_W-1:0] win_idx;
    logic             found;
    logic [BANKS-1:0] win_vec;

    // Scans from the top so the lowest matching index is kept last.
    always_comb begin
        win_idx = '0;
        found   = 1'b0;
        for (int b = BANKS - 1; b >= 0; b--) begin
            if (hits[b]) begin
                win_idx = IDX_W'(b);
                found   = 1'b1;
            end
        end
        win_vec = found ? (BANKS'(1) << win_idx) : '0;
    end

    // Registers the decision for the strobed address; idle clears outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || !strobe) begin
            cs_q  <= '0;
            idx_q <= '0;
            hit_q <= 1'b0;
        end else begin
            cs_q  <= win_vec;
            idx_q <= win_idx;
            hit_q <= found;
        end
    end

    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_q));

    p_idx_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> cs_q[idx_q]);

    p_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> (($past(hits) & (cs_q - BANKS'(1))) == '0));

    p_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strobe) && ($past(hits) != '0)) |-> hit_q);

    p_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hits) == '0) |-> (!hit_q && cs_q == '0 && idx_q == '0));

    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> (cs_q == '0 && !hit_q));
endmodule

// File: rtl/csdec_top.sv
// Module: top of the programmable chip-select decoder. Connects the
// register file, the comparator array and the priority/output stage.
// Assumes addresses are byte addresses; only bits 31:15 are decoded.
module csdec_top
    import csdec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 boot_low,
    input  logic                 cfg_wr,
    input  logic [IDX_W-1:0]     cfg_sel,
    input  logic                 cfg_kind,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    output logic [ADDR_W-1:0]    cfg_rdata,
    input  logic                 bus_valid,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_BANKS-1:0] cs,
    output logic [IDX_W-1:0]     cs_bank,
    output logic                 cs_hit
);
    bank_cfg_t [NUM_BANKS-1:0] cfg_w;
    logic      [NUM_BANKS-1:0] hits_w;
    logic                      unused_low_addr;

    assign unused_low_addr = ^bus_addr[LOW_W-1:0];

    csdec_regfile #(.BANKS(NUM_BANKS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_low (boot_low),
        .wr_en    (cfg_wr),
        .sel      (cfg_sel),
        .kind     (cfg_kind),
        .wr_data  (cfg_wdata),
        .rd_data  (cfg_rdata),
        .cfg_q    (cfg_w)
    );

    csdec_match #(.BANKS(NUM_BANKS)) u_match (
        .cfg     (cfg_w),
        .addr_hi (bus_addr[ADDR_W-1:LOW_W]),
        .hits    (hits_w)
    );

    csdec_prio #(.BANKS(NUM_BANKS)) u_prio (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (bus_valid),
        .hits   (hits_w),
        .cs_q   (cs),
        .idx_q  (cs_bank),
        .hit_q  (cs_hit)
    );

    // R8: an enabled bank 0 with an empty mask catches every strobe.
    p_catchall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && cfg_w[0].valid && cfg_w[0].mask == '0) |=> (cs_hit && cs_bank == '0));
endmodule

// File: tb/csdec_top_test.sv
`timescale 1ns/1ps
module csdec_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_low = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic        cfg_kind = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [11:0] cs;
    logic [3:0]  cs_bank;
    logic        cs_hit;

    int checks = 0;
    int errors = 0;

    logic [16:0] m_base [12];
    logic [16:0] m_mask [12];
    logic        m_val  [12];

    csdec_top uut (.*);

    always #2.5 clk = ~clk;

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] exp_dec(logic [31:0] a);
        // returns {hit, idx[3:0], cs[11:0]}
        for (int b = 0; b < 12; b++)
            if (m_val[b] && (((a[31:15] ^ m_base[b]) & m_mask[b]) == 17'h0))
                return {1'b1, 4'(b), 12'(1) << b};
        return '0;
    endfunction

    task automatic do_reset(bit strap);
        @(negedge clk);
        rst_n = 1'b0; boot_low = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < 12; b++) begin
            m_base[b] = '0; m_mask[b] = '0; m_val[b] = 1'b0;
        end
        m_base[0] = strap ? 17'h0 : 17'h1FC00;
        m_mask[0] = 17'h1FC00;
        m_val[0]  = 1'b1;
    endtask

    task automatic wr(int bank, bit kind, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 4'(bank); cfg_kind = kind; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (bank < 12) begin
            if (!kind) begin m_base[bank] = d[31:15]; m_val[bank] = d[0]; end
            else m_mask[bank] = d[31:15];
        end
    endtask

    task automatic rd(int bank, bit kind, logic [31:0] exp, string req);
        @(negedge clk);
        cfg_sel = 4'(bank); cfg_kind = kind;
        #1;
        chk(cfg_rdata == exp, req, cfg_rdata, exp);
    endtask

    task automatic probe(logic [31:0] a, string req);
        logic [16:0] e;
        logic [16:0] got;
        e = exp_dec(a);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        got = {cs_hit, cs_bank, cs};
        chk(got == e, req, 32'(got), 32'(e));
    endtask

    task automatic check_idle(string req);
        @(negedge clk);
        chk(!cs_hit && cs == '0 && cs_bank == '0, req, {19'h0, cs_hit, cs}, 32'h0);
    endtask

    initial begin
        logic [16:0] got;
        logic [16:0] e;
        // Low boot region
        do_reset(1'b1);
        check_idle("R12 reset outputs");
        rd(0, 1'b0, 32'h0000_0001, "R6 boot_low base readback");
        rd(0, 1'b1, 32'hFE00_0000, "R5 boot mask readback");
        rd(7, 1'b0, 32'h0000_0000, "R9 bank7 disabled");
        probe(32'h0000_0100, "R6 low boot vector");
        probe(32'h01FF_FFFF, "R5 low window top");
        probe(32'h0200_0000, "R11 just above low window");
        for (int i = 0; i < 128; i++)
            probe({7'(i), 25'h0AB_CDEF ^ 25'(i * 1237)}, "R5 top-bit sweep");

        // High boot region
        do_reset(1'b0);
        rd(0, 1'b0, 32'hFE00_0001, "R6 high base readback");
        probe(32'hFFF0_0100, "R6 high boot vector");
        probe(32'hFE00_0000, "R6 high window bottom");
        probe(32'hFDFF_FFFF, "R11 below high window");
        probe(32'h1234_5678, "R9 invalid banks miss");
        check_idle("R12 idle after probe");

        // Program banks
        wr(1, 1'b1, 32'hFFFF_8000);           // full mask
        wr(1, 1'b0, 32'h0000_0001);           // base 0
        wr(2, 1'b1, 32'hF000_0000);           // bits 31:28
        wr(2, 1'b0, 32'h4000_0001);
        wr(3, 1'b1, 32'hF800_0000);           // bits 31:27, overlaps bank 2
        wr(3, 1'b0, 32'h4800_0001);
        wr(5, 1'b1, 32'h8080_0000);           // bits 31 and 23
        wr(5, 1'b0, 32'h8000_0001);
        rd(5, 1'b0, 32'h8000_0001, "R1 base readback");
        rd(5, 1'b1, 32'h8080_0000, "R1 option readback");
        probe(32'h4800_0000, "R4 bank2 beats bank3");
        probe(32'h8000_0000, "R7 alias region a");
        probe(32'hC07F_0000, "R7 alias region b");
        probe(32'h8080_0000, "R7 masked-in bit blocks");
        probe(32'h0000_7FFF, "R3 low bits in block");
        probe(32'h0000_0000, "R3 block start");
        probe(32'h0000_8000, "R3 next block misses");
        for (int j = 0; j < 256; j++)
            probe((32'(j) << 24) | (32'(j & 1) << 23) | (32'(j & 15) << 15) | 32'((j * 13) & 32'h7FFF),
                  "R2 programmed sweep");

        // Write in the same cycle as a strobe
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 4'd1; cfg_kind = 1'b0; cfg_wdata = 32'h0001_0001;
        bus_valid = 1'b1; bus_addr = 32'h0000_0000;
        e = exp_dec(32'h0000_0000);
        @(negedge clk);
        cfg_wr = 1'b0; bus_valid = 1'b0;
        got = {cs_hit, cs_bank, cs};
        chk(got == e, "R10 same-cycle uses old value", 32'(got), 32'(e));
        m_base[1] = 17'h2; m_val[1] = 1'b1;
        probe(32'h0000_0000, "R10 new value after write");
        probe(32'h0001_0000, "R10 moved bank hits");

        // Out-of-range index
        wr(13, 1'b0, 32'h0000_0001);
        wr(13, 1'b1, 32'h0000_0000);
        rd(13, 1'b0, 32'h0000_0000, "R13 out-of-range read");
        probe(32'h5555_0000, "R13 decode unchanged");
        probe(32'h0001_0000, "R13 bank1 unchanged");

        // Catch-all bank 0
        wr(0, 1'b1, 32'h0000_0000);
        probe(32'h1234_5678, "R8 catch-all a");
        probe(32'h0000_0000, "R8 catch-all b");
        probe(32'h8000_0000, "R8 beats bank5");
        check_idle("R12 idle at end");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule